// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block catches message-signalled interrupts on behalf of a PCIe root port. It watches the stream of inbound memory requests coming up from endpoints. A full 32-bit write landing exactly on a programmable 64-bit doorbell address is claimed by the block. The write data is taken as a vector number, and the matching bit of a 32-bit status register is set, provided that vector is enabled. Every other inbound request, including a read of the doorbell address itself, is marked for forwarding as ordinary traffic.

Software reaches the block through a simple register port. The port holds the doorbell address (two 32-bit halves), a vector enable register, a vector mask register and the status register. A single level-sensitive interrupt line to the host rises when a doorbell write leaves an unmasked status bit set. It falls when software toggles the status register down to all zero. The doorbell window decodes only while at least one vector is enabled, so a freshly reset block absorbs nothing.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and the doorbell window is closed, so no inbound write is claimed.
- R2: A claimed doorbell write with vector N sets status bit N on the next clock edge if enable bit N is 1. If enable bit N is 0, the status is unchanged.
- R3: The vector number is the low 5 bits of the write data, so a data value of 32 or more selects bit (value mod 32).
- R4: `irq` rises one clock after a claimed doorbell write that leaves any status bit set whose mask bit is 0. A doorbell that leaves only masked bits set does not raise it.
- R5: A register write to the status offset inverts every status bit that is 1 in the write data. `irq` drops on the next clock edge if the resulting status is all zero, and otherwise holds its value.
- R6: The window is open only while the enable register is nonzero. Writing the low half (offset 0x820) or the high half (offset 0x824) of the address replaces only that half. Address and enable changes govern claims from the next cycle on.
- R7: Only a write with all four byte enables set (`ib_be` = 4'hF) and an address exactly equal to the doorbell address is claimed. Anything else is forwarded (`ib_fwd` = 1) and leaves the status untouched.
- R8: An inbound read of the doorbell address is never claimed and is forwarded.
- R9: A write to the mask register (offset 0x82C) alone never changes `irq`.
- R10: When a doorbell claim and a status write fall in the same cycle, the new status is (old status XOR write data) OR the set vector bit. `irq` goes to 1 if that result has an unmasked bit. Otherwise `irq` goes to 0 if the result is zero, and otherwise it holds.
- R11: `reg_rdata` combinationally shows the register at `reg_addr`: 0x820 address low, 0x824 address high, 0x828 enable, 0x82C mask, 0x830 status. Any other offset reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ib_valid | input | 1 | Inbound request present this cycle |
| ib_write | input | 1 | Inbound request is a write (0 = read) |
| ib_addr | input | 64 | Inbound request address |
| ib_be | input | 4 | Inbound byte enables |
| ib_wdata | input | 32 | Inbound write data (vector number) |
| ib_claim | output | 1 | Request absorbed as a doorbell write |
| ib_fwd | output | 1 | Request passed on as ordinary traffic |
| irq | output | 1 | Level interrupt to the host |

## Verification
The two functions that can meet in one cycle are doorbell capture and the software status toggle, since they change the same register and steer the interrupt in opposite directions. The bench provokes the meeting with directed cycles: one with a claimed enabled vector beside a clearing status write, and one with a claim of a disabled vector beside a write that empties the status. A random phase then mixes both kinds of traffic aimed at the doorbell address. Each cycle is judged against a behavioural model that applies the toggle first, ORs in the captured bit, lets a raise win over a drop, and compares claim, forward, read data and `irq`.

// File: rtl/msi_dbl_pkg.sv
package msi_dbl_pkg;

    parameter int unsigned REG_AW = 12;

    localparam logic [REG_AW-1:0] OFF_ADDR_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFF_ADDR_HI = 12'h824;
    localparam logic [REG_AW-1:0] OFF_VEC_EN  = 12'h828;
    localparam logic [REG_AW-1:0] OFF_VEC_MSK = 12'h82C;
    localparam logic [REG_AW-1:0] OFF_VEC_STS = 12'h830;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADDR_LO,
        SEL_ADDR_HI,
        SEL_VEC_EN,
        SEL_VEC_MSK,
        SEL_VEC_STS
    } reg_sel_e;

endpackage

// File: rtl/msi_dbl_regdec.sv
module msi_dbl_regdec
    import msi_dbl_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            OFF_ADDR_LO: sel = SEL_ADDR_LO;
            OFF_ADDR_HI: sel = SEL_ADDR_HI;
            OFF_VEC_EN:  sel = SEL_VEC_EN;
            OFF_VEC_MSK: sel = SEL_VEC_MSK;
            OFF_VEC_STS: sel = SEL_VEC_STS;
            default:     sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/msi_dbl_match.sv
module msi_dbl_match #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned BE_W   = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [ADDR_W-1:0] win_base,
    input  logic              win_open,
    output logic              hit
);

    logic addr_eq;
    logic full_word;

    always_comb begin
        addr_eq   = (req_addr == win_base);
        full_word = &req_be;
        hit       = req_valid && req_write && full_word && addr_eq && win_open;
    end

endmodule

// File: rtl/msi_dbl_vecdec.sv
module msi_dbl_vecdec #(
    parameter int unsigned NVEC = 32
) (
    input  logic [NVEC-1:0] data,
    input  logic [NVEC-1:0] enable,
    output logic [NVEC-1:0] set_mask
);

    localparam int unsigned VEC_W = $clog2(NVEC);

    logic [VEC_W-1:0] vec_num;

    assign vec_num = data[VEC_W-1:0];

    for (genvar g = 0; g < NVEC; g++) begin : g_bit
        assign set_mask[g] = (vec_num == VEC_W'(g)) && enable[g];
    end

endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
    import msi_dbl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BE_W   = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  ib_valid,
    input  logic                  ib_write,
    input  logic [2*DATA_W-1:0]   ib_addr,
    input  logic [BE_W-1:0]       ib_be,
    input  logic [DATA_W-1:0]     ib_wdata,
    output logic                  ib_claim,
    output logic                  ib_fwd,
    output logic                  irq
);

    localparam int unsigned ADDR_W = 2 * DATA_W;
    localparam int unsigned NVEC   = DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [NVEC-1:0]   en;
        logic [NVEC-1:0]   msk;
        logic [NVEC-1:0]   sts;
        logic              irq;
    } state_t;

    state_t   st_q;
    state_t   st_d;
    reg_sel_e sel;
    logic [NVEC-1:0] set_vec;
    logic [NVEC-1:0] sts_tog;
    logic [NVEC-1:0] sts_new;
    logic            sts_wr;
    logic            win_open;
    logic [NVEC-1:0] en_q;
    logic [NVEC-1:0] sts_q;

    assign win_open = |st_q.en;
    assign en_q     = st_q.en;
    assign sts_q    = st_q.sts;

    msi_dbl_regdec u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    msi_dbl_match #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_match (
        .req_valid (ib_valid),
        .req_write (ib_write),
        .req_addr  (ib_addr),
        .req_be    (ib_be),
        .win_base  (st_q.base),
        .win_open  (win_open),
        .hit       (ib_claim)
    );

    msi_dbl_vecdec #(
        .NVEC (NVEC)
    ) u_vec (
        .data     (ib_wdata),
        .enable   (st_q.en),
        .set_mask (set_vec)
    );

    assign ib_fwd = ib_valid && !ib_claim;

    // Next-state computation
    always_comb begin
        st_d    = st_q;
        sts_wr  = 1'b0;
        sts_tog = st_q.sts;
        if (reg_we) begin
            unique case (sel)
                SEL_ADDR_LO: st_d.base[DATA_W-1:0]      = reg_wdata;
                SEL_ADDR_HI: st_d.base[ADDR_W-1:DATA_W] = reg_wdata;
                SEL_VEC_EN:  st_d.en  = reg_wdata;
                SEL_VEC_MSK: st_d.msk = reg_wdata;
                SEL_VEC_STS: begin
                    sts_wr  = 1'b1;
                    sts_tog = st_q.sts ^ reg_wdata;
                end
                default: ;
            endcase
        end
        sts_new  = sts_tog | (ib_claim ? set_vec : '0);
        st_d.sts = sts_new;
        if (ib_claim && (|(sts_new & ~st_q.msk))) begin
            st_d.irq = 1'b1;
        end else if (sts_wr && (sts_new == '0)) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Register read mux
    always_comb begin
        unique case (sel)
            SEL_ADDR_LO: reg_rdata = st_q.base[DATA_W-1:0];
            SEL_ADDR_HI: reg_rdata = st_q.base[ADDR_W-1:DATA_W];
            SEL_VEC_EN:  reg_rdata = st_q.en;
            SEL_VEC_MSK: reg_rdata = st_q.msk;
            SEL_VEC_STS: reg_rdata = st_q.sts;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/msi_dbl_chk.sv
module msi_dbl_chk
    import msi_dbl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BE_W   = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              ib_valid,
    input logic              ib_write,
    input logic [BE_W-1:0]   ib_be,
    input logic              ib_claim,
    input logic              ib_fwd,
    input logic              irq,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] sts_q
);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (irq == 1'b0 && en_q == '0 && sts_q == '0)
                else $error("reset state not idle");
        end
    end

    a_r2_status_only_by_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ib_claim) |-> ((sts_q & ~$past(sts_q)) == '0 || $past(reg_we && reg_addr == OFF_VEC_STS)))
        else $error("status bit set without a claim");

    a_r4_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ib_claim))
        else $error("irq rose without a doorbell claim");

    a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we && reg_addr == OFF_VEC_STS))
        else $error("irq fell without a status write");

    a_r6_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !ib_claim)
        else $error("claim while window closed");

    a_r7_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_be != '1) |-> !ib_claim)
        else $error("claim of a partial write");

    a_r8_read_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_valid && !ib_write) |-> (ib_fwd && !ib_claim))
        else $error("read was claimed");

    a_r9_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_VEC_MSK && !ib_claim) |=> $stable(irq))
        else $error("mask write moved irq");

endmodule

bind msi_doorbell_ctrl msi_dbl_chk #(
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .ib_valid (ib_valid),
    .ib_write (ib_write),
    .ib_be    (ib_be),
    .ib_claim (ib_claim),
    .ib_fwd   (ib_fwd),
    .irq      (irq),
    .en_q     (en_q),
    .sts_q    (sts_q)
);

// File: tb/msi_doorbell_ctrl_tb_top.sv
module msi_doorbell_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        ib_valid;
    logic        ib_write;
    logic [63:0] ib_addr;
    logic [3:0]  ib_be;
    logic [31:0] ib_wdata;
    logic        ib_claim;
    logic        ib_fwd;
    logic        irq;

    always #10 clk = ~clk;

    msi_doorbell_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ib_valid  (ib_valid),
        .ib_write  (ib_write),
        .ib_addr   (ib_addr),
        .ib_be     (ib_be),
        .ib_wdata  (ib_wdata),
        .ib_claim  (ib_claim),
        .ib_fwd    (ib_fwd),
        .irq       (irq)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    bit [63:0] m_base;
    bit [31:0] m_en, m_msk, m_sts;
    bit        m_irq;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] model_rd(input bit [11:0] a);
        if (a == 12'h820) return m_base[31:0];
        if (a == 12'h824) return m_base[63:32];
        if (a == 12'h828) return m_en;
        if (a == 12'h82C) return m_msk;
        if (a == 12'h830) return m_sts;
        return 32'd0;
    endfunction

    task automatic idle_inputs();
        reg_we = 0; reg_addr = 12'h000; reg_wdata = 0;
        ib_valid = 0; ib_write = 0; ib_addr = 0; ib_be = 0; ib_wdata = 0;
    endtask

    // One clock: check combinational outputs, advance model, check irq
    task automatic tick();
        bit        e_claim;
        bit [31:0] nsts;
        bit        sw;
        bit [63:0] nbase;
        bit [31:0] nen, nmsk;
        bit        nirq;
        int        v;
        #2;
        e_claim = ib_valid && ib_write && (ib_be == 4'hF) && (ib_addr == m_base) && (m_en != 0);
        chk("ib_claim", ib_claim, e_claim);
        chk("ib_fwd", ib_fwd, ib_valid && !e_claim);
        chk("reg_rdata", reg_rdata, model_rd(reg_addr));
        nbase = m_base; nen = m_en; nmsk = m_msk; nsts = m_sts; nirq = m_irq; sw = 0;
        if (reg_we) begin
            if (reg_addr == 12'h820) nbase[31:0]  = reg_wdata;
            if (reg_addr == 12'h824) nbase[63:32] = reg_wdata;
            if (reg_addr == 12'h828) nen  = reg_wdata;
            if (reg_addr == 12'h82C) nmsk = reg_wdata;
            if (reg_addr == 12'h830) begin sw = 1; nsts = m_sts ^ reg_wdata; end
        end
        if (e_claim) begin
            v = int'(ib_wdata % 32);
            if (m_en[v]) nsts[v] = 1'b1;
        end
        if (e_claim && ((nsts & ~m_msk) != 0)) nirq = 1;
        else if (sw && nsts == 0) nirq = 0;
        @(posedge clk);
        #1;
        m_base = nbase; m_en = nen; m_msk = nmsk; m_sts = nsts; m_irq = nirq;
        chk("irq", irq, m_irq);
        @(negedge clk);
    endtask

    task automatic reg_wr(input bit [11:0] a, input bit [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0;
    endtask

    task automatic reg_rd(input bit [11:0] a);
        reg_addr = a;
        tick();
    endtask

    task automatic ib_req(input bit w, input bit [63:0] a, input bit [3:0] be, input bit [31:0] d);
        ib_valid = 1; ib_write = w; ib_addr = a; ib_be = be; ib_wdata = d;
        tick();
        ib_valid = 0; ib_write = 0;
    endtask

    localparam bit [63:0] BASE = 64'h0000_00F0_FEE0_1000;

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        m_base = 0; m_en = 0; m_msk = 0; m_sts = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and closed window
        cur_req = "R1";
        chk("irq after reset", irq, 0);
        reg_rd(12'h820); reg_rd(12'h824); reg_rd(12'h828); reg_rd(12'h82C); reg_rd(12'h830);
        ib_req(1, 64'd0, 4'hF, 32'd0);
        chk("no claim at reset", m_sts, 0);

        // R11: register map and unmapped offset
        cur_req = "R11";
        reg_wr(12'h834, 32'hFFFF_FFFF);
        reg_rd(12'h834);
        reg_rd(12'h830);

        // R6: address halves written independently
        cur_req = "R6";
        reg_wr(12'h820, 32'h1111_1111);
        reg_wr(12'h824, BASE[63:32]);
        reg_wr(12'h820, BASE[31:0]);
        reg_rd(12'h824);
        chk("hi half kept", reg_rdata, BASE[63:32]);
        ib_req(1, BASE, 4'hF, 32'd0);   // still closed: enable is zero

        // R2: enabled and disabled vectors
        cur_req = "R2";
        reg_wr(12'h828, 32'h0000_00F5);
        ib_req(1, BASE, 4'hF, 32'd1);   // bit 1 disabled
        chk("disabled vector ignored", m_sts, 0);
        cur_req = "R4";
        ib_req(1, BASE, 4'hF, 32'd0);   // bit 0 enabled, unmasked
        chk("irq raised", irq, 1);

        // R3: vector modulo 32
        cur_req = "R3";
        ib_req(1, BASE, 4'hF, 32'd34);
        reg_rd(12'h830);
        chk("bit2 from 34", reg_rdata, 32'h5);

        // R7 / R8: partial, misaddressed and read requests
        cur_req = "R7";
        ib_req(1, BASE, 4'h3, 32'd4);
        ib_req(1, BASE + 64'd4, 4'hF, 32'd4);
        cur_req = "R8";
        ib_req(0, BASE, 4'hF, 32'd4);
        reg_rd(12'h830);

        // R9: mask change alone holds irq
        cur_req = "R9";
        reg_wr(12'h82C, 32'hFFFF_FFFF);
        chk("irq held on mask", irq, 1);

        // R5: partial toggle holds, full clear drops
        cur_req = "R5";
        reg_wr(12'h830, 32'h1);
        chk("irq held partial", irq, 1);
        reg_wr(12'h830, 32'h4);
        chk("irq dropped", irq, 0);

        // R4: masked doorbell does not raise
        cur_req = "R4";
        ib_req(1, BASE, 4'hF, 32'd4);
        chk("masked no irq", irq, 0);
        cur_req = "R9";
        reg_wr(12'h82C, 32'h0);
        chk("unmask no irq", irq, 0);

        // R10: coincident doorbell and status write
        cur_req = "R10";
        reg_we = 1; reg_addr = 12'h830; reg_wdata = 32'h10;
        ib_valid = 1; ib_write = 1; ib_addr = BASE; ib_be = 4'hF; ib_wdata = 32'd5;
        tick();
        chk("coincident raise", irq, 1);
        reg_wdata = 32'h20; ib_wdata = 32'd3;   // disabled vector, status empties
        tick();
        chk("coincident drop", irq, 0);
        idle_inputs();

        // R6: moving and closing the window
        cur_req = "R6";
        reg_wr(12'h824, 32'h0000_0001);
        ib_req(1, BASE, 4'hF, 32'd6);
        ib_req(1, {32'h1, BASE[31:0]}, 4'hF, 32'd6);
        reg_wr(12'h828, 32'h0);
        ib_req(1, {32'h1, BASE[31:0]}, 4'hF, 32'd7);
        reg_wr(12'h824, BASE[63:32]);
        reg_wr(12'h828, 32'hFFFF_FFFF);

        // R10: random mix around the doorbell
        cur_req = "R10";
        for (int i = 0; i < 600; i++) begin
            bit [2:0] pick;
            pick = 3'($urandom_range(0, 5));
            reg_we    = ($urandom_range(0, 2) == 0);
            reg_addr  = (pick == 5) ? 12'h834 : (12'h820 + 12'(pick) * 12'd4);
            if (reg_we && (pick == 0 || pick == 1)) reg_we = 0;
            reg_wdata = $urandom();
            if (reg_addr == 12'h828 && $urandom_range(0, 3) == 0) reg_wdata = 0;
            ib_valid  = ($urandom_range(0, 1) == 1);
            ib_write  = ($urandom_range(0, 3) != 0);
            ib_addr   = ($urandom_range(0, 4) == 0) ? BASE + 64'd4 : BASE;
            ib_be     = ($urandom_range(0, 4) == 0) ? 4'h7 : 4'hF;
            ib_wdata  = $urandom_range(0, 80);
            tick();
        end
        idle_inputs();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule